// File: doc/BRIEF.md
# SM3 Message Expansion Unit

This unit takes one 512-bit message block and supplies a compression core with the expanded schedule of the SM3 hash. The block arrives on a single wide input. It is split into sixteen 32-bit words, and the first byte of each word is taken as its most significant byte. After a load, the unit presents the round-0 pair: the expanded word W[j] and the companion word W'[j] = W[j] XOR W[j+4]. Each `next` strobe moves the output to the following round. After round 63 the unit stays put until a new block is loaded.

The unit does not store all 68 expanded words. It keeps a 16-word sliding window in which slot k holds W[j+k]. Slot 4 therefore supplies W[j+4], the word four rounds ahead, so the companion output needs no extra storage. On each advance the window shifts by one word. A new word W[j+16] enters at the top, built from five window taps through the P1 permutation. Message padding and the compression rounds are handled outside this unit.

Top module: `sm3_msg_expand`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and `roundIdx` is 0 until the first load.
- R2: On the cycle after `load` is high, `outValid` is 1, `roundIdx` is 0 and `wordW` equals `blockIn[511:480]`. Message word i is `blockIn[511-32*i -: 32]`, so the first byte of the stream (bits 511:504) is the most significant byte of word 0.
- R3: For rounds 0 to 15, `wordW` equals message word `roundIdx` of the loaded block.
- R4: For rounds 16 to 63, `wordW` equals P1(W[j-16] ^ W[j-9] ^ rol(W[j-3],15)) ^ rol(W[j-13],7) ^ W[j-6], where P1(x) = x ^ rol(x,15) ^ rol(x,23) and rol is a 32-bit left rotation.
- R5: For every round j from 0 to 63, `wordWp` equals W[j] ^ W[j+4]. This needs expanded words up to W[67].
- R6: While `outValid` is 1 and both `next` and `load` are low, `wordW`, `wordWp` and `roundIdx` keep their values.
- R7: When `outValid` is 1, `next` is high, `load` is low and `roundIdx` is below 63, the next cycle shows round `roundIdx`+1.
- R8: When `roundIdx` is 63, `next` has no effect: the round index and both words stay unchanged until a load.
- R9: `load` takes priority over `next`. A load in the middle of a sequence restarts at round 0 with the new block.
- R10: Before the first load, `next` has no effect and `outValid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Captures `blockIn` and restarts at round 0 |
| blockIn | input | 512 | Message block, first byte in bits 511:504 |
| next | input | 1 | Advances to the next round |
| outValid | output | 1 | A pair is present on the outputs |
| roundIdx | output | 6 | Round j of the pair being presented |
| wordW | output | 32 | Expanded word W[j] |
| wordWp | output | 32 | Companion word W[j] ^ W[j+4] |

## Verification
The assertions assume that `load` and `next` are known 0/1 levels from reset onward and may be raised in any combination, including together and before any load. The stimulus drives both strobes low from time zero. It then mixes random gaps between advances, extra advances past round 63, strobes issued before any load, and a load that collides with `next`, so every sequence of legal strobes is fair game. Random blocks come from a fixed seed, alongside one directed block with a known byte pattern.

// File: rtl/sm3x_pkg.sv
package sm3x_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadEn;
    logic shiftEn;
  } sm3x_ctrl_t;

  function automatic word_t rotl(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic word_t permP1(input word_t x);
    return x ^ rotl(x, 15) ^ rotl(x, 23);
  endfunction
endpackage

// File: rtl/sm3x_ctrl.sv
module sm3x_ctrl
  import sm3x_pkg::*;
#(
  parameter int NUM_ROUNDS = 64,
  localparam int RND_W = $clog2(NUM_ROUNDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             next,
  output sm3x_ctrl_t       ctrl,
  output logic             outValid,
  output logic [RND_W-1:0] roundIdx
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

  logic atLast;
  assign atLast = (roundIdx == LAST_RND);

  always_comb begin
    ctrl.loadEn  = load;
    ctrl.shiftEn = !load && next && outValid && !atLast;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      roundIdx <= '0;
    end else if (ctrl.loadEn) begin
      outValid <= 1'b1;
      roundIdx <= '0;
    end else if (ctrl.shiftEn) begin
      roundIdx <= roundIdx + 1'b1;
    end
  end
endmodule

// File: rtl/sm3x_datapath.sv
module sm3x_datapath
  import sm3x_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int LEAD      = 4,
  localparam int BLOCK_W  = WORD_W * NUM_WORDS
) (
  input  logic               clk,
  input  logic               rstN,
  input  sm3x_ctrl_t         ctrl,
  input  logic [BLOCK_W-1:0] blockIn,
  output word_t              wordW,
  output word_t              wordWp
);
  // window slot k holds W[j+k]; taps for W[j+16]
  localparam int TAP16 = NUM_WORDS - 16;
  localparam int TAP13 = NUM_WORDS - 13;
  localparam int TAP9  = NUM_WORDS - 9;
  localparam int TAP6  = NUM_WORDS - 6;
  localparam int TAP3  = NUM_WORDS - 3;

  word_t win [NUM_WORDS];
  word_t newWord;

  assign newWord = permP1(win[TAP16] ^ win[TAP9] ^ rotl(win[TAP3], 15))
                 ^ rotl(win[TAP13], 7) ^ win[TAP6];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_slot
    word_t shiftIn;
    if (k == NUM_WORDS - 1) begin : g_top
      assign shiftIn = newWord;
    end else begin : g_mid
      assign shiftIn = win[k+1];
    end

    always_ff @(posedge clk) begin
      if (!rstN)             win[k] <= '0;
      else if (ctrl.loadEn)  win[k] <= blockIn[BLOCK_W-1-k*WORD_W -: WORD_W];
      else if (ctrl.shiftEn) win[k] <= shiftIn;
    end
  end

  assign wordW  = win[0];
  assign wordWp = win[0] ^ win[LEAD];
endmodule

// File: rtl/sm3_msg_expand.sv
module sm3_msg_expand
  import sm3x_pkg::*;
#(
  parameter int NUM_WORDS  = 16,
  parameter int NUM_ROUNDS = 64,
  parameter int LEAD       = 4,
  localparam int BLOCK_W   = WORD_W * NUM_WORDS,
  localparam int RND_W     = $clog2(NUM_ROUNDS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               load,
  input  logic [BLOCK_W-1:0] blockIn,
  input  logic               next,
  output logic               outValid,
  output logic [RND_W-1:0]   roundIdx,
  output logic [WORD_W-1:0]  wordW,
  output logic [WORD_W-1:0]  wordWp
);
  sm3x_ctrl_t ctrl;

  sm3x_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) ctrl_i (
    .clk(clk), .rstN(rstN), .load(load), .next(next),
    .ctrl(ctrl), .outValid(outValid), .roundIdx(roundIdx)
  );

  sm3x_datapath #(.NUM_WORDS(NUM_WORDS), .LEAD(LEAD)) dp_i (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .blockIn(blockIn),
    .wordW(wordW), .wordWp(wordWp)
  );
endmodule

// File: rtl/sm3x_checker.sv
module sm3x_checker #(
  parameter int WORD_W     = 32,
  parameter int NUM_ROUNDS = 64,
  localparam int RND_W     = $clog2(NUM_ROUNDS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              load,
  input logic              next,
  input logic [WORD_W-1:0] firstWord,
  input logic              outValid,
  input logic [RND_W-1:0]  roundIdx,
  input logic [WORD_W-1:0] wordW
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(NUM_ROUNDS - 1);

  p_first_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    load |=> outValid && roundIdx == '0 && wordW == $past(firstWord));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !next && !load |=> $stable(wordW) && $stable(roundIdx) && outValid);

  p_advance_r7: assert property (@(posedge clk) disable iff (!rstN)
    outValid && next && !load && roundIdx != LAST_RND |=> roundIdx == $past(roundIdx) + 1'b1);

  p_stop_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && next && !load && roundIdx == LAST_RND |=> roundIdx == LAST_RND && $stable(wordW));

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    load && next |=> roundIdx == '0 && outValid);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !outValid && !load |=> !outValid && roundIdx == '0);
endmodule

bind sm3_msg_expand sm3x_checker #(.WORD_W(32), .NUM_ROUNDS(NUM_ROUNDS)) chk_i (
  .clk(clk), .rstN(rstN), .load(load), .next(next),
  .firstWord(blockIn[BLOCK_W-1 -: 32]),
  .outValid(outValid), .roundIdx(roundIdx), .wordW(wordW)
);

// File: tb/sm3_msg_expand_tb.sv
module sm3_msg_expand_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         load = 1'b0;
  logic         next = 1'b0;
  logic [511:0] blockIn = '0;
  logic         outValid;
  logic [5:0]   roundIdx;
  logic [31:0]  wordW, wordWp;

  int errors = 0;
  int checks = 0;
  logic [31:0] refW [68];

  always #(CLK_PERIOD/2) clk = ~clk;

  sm3_msg_expand dut_i (
    .clk(clk), .rstN(rstN), .load(load), .blockIn(blockIn), .next(next),
    .outValid(outValid), .roundIdx(roundIdx), .wordW(wordW), .wordWp(wordWp)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  task automatic buildRef(input logic [511:0] blk);
    for (int i = 0; i < 16; i++) refW[i] = blk[511-32*i -: 32];
    for (int j = 16; j < 68; j++) begin
      logic [31:0] t;
      t = refW[j-16] ^ refW[j-9] ^ rl(refW[j-3], 15);
      refW[j] = (t ^ rl(t, 15) ^ rl(t, 23)) ^ rl(refW[j-13], 7) ^ refW[j-6];
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full-state check of the pair presented for round j
  task automatic checkRound(input string req, input int j);
    check({req, " valid"}, 32'(outValid), 32'd1);
    check({req, " round"}, 32'(roundIdx), 32'(j));
    check({req, " W"},  wordW,  refW[j]);
    check({req, " Wp"}, wordWp, refW[j] ^ refW[j+4]);
  endtask

  task automatic doLoad(input logic [511:0] blk, input logic withNext);
    blockIn = blk; load = 1'b1; next = withNext;
    @(negedge clk);
    load = 1'b0; next = 1'b0;
    buildRef(blk);
  endtask

  task automatic step();
    next = 1'b1;
    @(negedge clk);
    next = 1'b0;
  endtask

  // walk all 64 rounds; random hold gaps when randGaps is set
  task automatic walk(input logic randGaps);
    for (int j = 0; j < 64; j++) begin
      checkRound(j < 16 ? "R3" : "R4/R5", j);
      if (randGaps && ($urandom % 4 == 0)) begin
        repeat (1 + $urandom % 3) @(negedge clk);
        checkRound("R6 hold", j);
      end
      if (j < 63) step();
    end
  endtask

  function automatic logic [511:0] randBlock();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[511-32*i -: 32] = $urandom;
    return b;
  endfunction

  initial begin
    int cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [511:0] blk;
    void'($urandom(32'h5EED_0003));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 valid", 32'(outValid), 32'd0);
    check("R1 round", 32'(roundIdx), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 valid after release", 32'(outValid), 32'd0);

    // R10: next before any load
    step(); step();
    check("R10 valid", 32'(outValid), 32'd0);
    check("R10 round", 32'(roundIdx), 32'd0);

    // R2: directed byte pattern, bytes 0x00..0x3F in stream order
    for (int i = 0; i < 64; i++) blk[511-8*i -: 8] = 8'(i);
    doLoad(blk, 1'b0);
    check("R2 first word", wordW, 32'h00010203);
    check("R2 round", 32'(roundIdx), 32'd0);
    check("R2 valid", 32'(outValid), 32'd1);
    walk(1'b0);

    // R8: next at round 63 ignored
    repeat (3) step();
    checkRound("R8", 63);

    // random blocks with random hold gaps
    for (int b = 0; b < 4; b++) begin
      doLoad(randBlock(), 1'b0);
      walk(1'b1);
    end

    // R9: mid-sequence load collides with next
    doLoad(randBlock(), 1'b0);
    repeat (20) step();
    checkRound("R9 pre", 20);
    doLoad(randBlock(), 1'b1);
    checkRound("R9 restart", 0);
    walk(1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule